// File: doc/BRIEF.md
# Asynchronous Static Memory Read Timing Generator

This block runs one read cycle on an external asynchronous static memory. Once a request is accepted, it drives the address and active-low byte selects for the whole cycle. It shapes an active-low chip-select strobe and an active-low read strobe, each from its own setup and pulse counts, and it captures the 16-bit read data. All counts are in controller clock cycles. The read-strobe cycle count sets the total length of the cycle.

The two strobes are produced by separate generators that never compare their timings. A capture-select input, latched with the rest of the timing when the request is accepted, decides whose rising edge samples the data bus. The edge that drives the selected strobe high is the edge at which the data is captured, whatever the other strobe is doing. At the end of the cycle a one-clock done pulse is raised. The captured word stays on `rdata_o` until a later cycle captures again.

Top module: `async_rd_timer`

## Requirements
- R1: After reset, `mem_cs_no`, `mem_rd_no` and both bits of `mem_be_no` are high, `done_o` is low and `rdata_o` is zero.
- R2: Number the clocks after the accepting edge k = 0, 1, 2 and so on. `mem_rd_no` is low exactly for k in [S, min(S+P, L)), where S is the read setup, P the read pulse and L the cycle length.
- R3: `mem_cs_no` is low exactly for k in [S, min(S+P, L)), using the chip-select setup and pulse. It is independent of the read-strobe settings, except that it is forced high when the cycle ends.
- R4: A pulse setting of zero acts as a pulse of one clock, for either strobe.
- R5: When the capture-select input is 1, `rdata_o` takes the value `mem_data_i` had at the clock edge that drives `mem_rd_no` high.
- R6: When the capture-select input is 0, `rdata_o` takes the value `mem_data_i` had at the clock edge that drives `mem_cs_no` high.
- R7: The cycle length L is `rd_cycle_i`, with 0 treated as 1. `done_o` is high for exactly the one clock that follows clock k = L-1, and both strobes are high during that clock.
- R8: During the cycle, `mem_addr_o` carries the latched address and `mem_be_no` carries the inverse of the latched byte enables (bit 0 is the low byte, bit 1 the high byte). `mem_be_no` is 2'b11 while idle, and `mem_addr_o` keeps its last value.
- R9: With setup 0 and pulse equal to L, the strobe is low from k = 0 through k = L-1.
- R10: Timing, capture-select, address and byte enables are latched at acceptance. Changing them during a cycle does not alter that cycle.
- R11: `req_i` is ignored while a cycle is in progress. A request that is high during the done clock starts a new cycle at the next edge.
- R12: `rdata_o` does not change between the end of a cycle and the next capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request, accepted when idle |
| addr_i | input | AW | Read address |
| be_i | input | 2 | Byte enables, active high |
| rd_setup_i | input | CW | Read strobe setup, clocks |
| rd_pulse_i | input | CW | Read strobe pulse, clocks |
| rd_cycle_i | input | CW | Total cycle length, clocks |
| cs_setup_i | input | CW | Chip-select setup, clocks |
| cs_pulse_i | input | CW | Chip-select pulse, clocks |
| cap_rd_i | input | 1 | 1: capture on read strobe rise, 0: on chip-select rise |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| rdata_o | output | DW | Captured read data |
| mem_addr_o | output | AW | Memory address pins |
| mem_be_no | output | 2 | Byte selects, active low |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_rd_no | output | 1 | Read strobe, active low |
| mem_data_i | input | DW | Memory data bus |

## Verification
A wrong cycle counter shows at the strobe pins one clock after it goes wrong, as an edge that is early or late. It also moves `done_o`, which is compared on the same clock. A wrong latched capture-select or stop value stays hidden until the capture edge. From that edge onward, `rdata_o` holds a bus value one or more clocks off, and that error persists until the next cycle. The bench drives a data bus that changes on every clock, so a capture one edge off always gives a different word.

// File: rtl/art_pkg.sv
package art_pkg;
  typedef enum logic {CAP_CS = 1'b0, CAP_RD = 1'b1} cap_sel_e;
endpackage

// File: rtl/art_cfg_latch.sv
module art_cfg_latch #(
  parameter int unsigned CW = 6,
  localparam int unsigned LW = CW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CW-1:0]      rd_setup_i,
  input  logic [CW-1:0]      rd_pulse_i,
  input  logic [CW-1:0]      rd_cycle_i,
  input  logic [CW-1:0]      cs_setup_i,
  input  logic [CW-1:0]      cs_pulse_i,
  input  art_pkg::cap_sel_e  cap_sel_i,
  output logic [LW-1:0]      len_o,
  output logic [LW-1:0]      rd_setup_o,
  output logic [LW-1:0]      rd_stop_o,
  output logic [LW-1:0]      cs_setup_o,
  output logic [LW-1:0]      cs_stop_o,
  output art_pkg::cap_sel_e  cap_sel_o
);
  // zero pulse acts as one; strobe end clipped to cycle end
  function automatic logic [LW-1:0] stop_of(input logic [CW-1:0] s, input logic [CW-1:0] p,
                                            input logic [LW-1:0] len);
    logic [LW-1:0] e;
    e = LW'(s) + ((p == '0) ? LW'(1) : LW'(p));
    return (e > len) ? len : e;
  endfunction

  logic [LW-1:0] len_d;
  assign len_d = (rd_cycle_i == '0) ? LW'(1) : LW'(rd_cycle_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_o      <= LW'(1);
      rd_setup_o <= '0;
      rd_stop_o  <= LW'(1);
      cs_setup_o <= '0;
      cs_stop_o  <= LW'(1);
      cap_sel_o  <= art_pkg::CAP_RD;
    end else if (load_i) begin
      len_o      <= len_d;
      rd_setup_o <= LW'(rd_setup_i);
      rd_stop_o  <= stop_of(rd_setup_i, rd_pulse_i, len_d);
      cs_setup_o <= LW'(cs_setup_i);
      cs_stop_o  <= stop_of(cs_setup_i, cs_pulse_i, len_d);
      cap_sel_o  <= cap_sel_i;
    end
  end
endmodule

// File: rtl/art_seq.sv
module art_seq #(
  parameter int unsigned CW = 6,
  localparam int unsigned LW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  output logic          active_o,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  logic last;
  assign last = active_o && ({1'b0, cnt_o} == len_i - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= last;
      if (start_i) begin
        active_o <= 1'b1;
        cnt_o    <= '0;
      end else if (last) begin
        active_o <= 1'b0;
      end else if (active_o) begin
        cnt_o <= cnt_o + CW'(1);
      end
    end
  end
endmodule

// File: rtl/art_strobe.sv
module art_strobe #(
  parameter int unsigned CW = 6,
  localparam int unsigned LW = CW + 1
) (
  input  logic          active_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [LW-1:0] setup_i,
  input  logic [LW-1:0] stop_i,
  output logic          strobe_no,
  output logic          rise_o
);
  logic [LW-1:0] cnt_w;
  assign cnt_w     = {1'b0, cnt_i};
  assign strobe_no = !(active_i && (cnt_w >= setup_i) && (cnt_w < stop_i));
  // next edge is the one that ends the pulse window
  assign rise_o    = active_i && (cnt_w + LW'(1) == stop_i);
endmodule

// File: rtl/async_rd_timer.sv
module async_rd_timer #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    be_i,
  input  logic [CW-1:0] rd_setup_i,
  input  logic [CW-1:0] rd_pulse_i,
  input  logic [CW-1:0] rd_cycle_i,
  input  logic [CW-1:0] cs_setup_i,
  input  logic [CW-1:0] cs_pulse_i,
  input  logic          cap_rd_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_be_no,
  output logic          mem_cs_no,
  output logic          mem_rd_no,
  input  logic [DW-1:0] mem_data_i
);
  import art_pkg::*;
  localparam int unsigned LW = CW + 1;
  localparam int unsigned NS = 2; // 0: chip select, 1: read strobe

  logic          active, accept;
  logic [CW-1:0] cnt;
  logic [LW-1:0] len;
  cap_sel_e      cap_sel_q;
  logic [NS-1:0][LW-1:0] st_setup, st_stop;
  logic [NS-1:0] st_n, st_rise;
  logic [1:0]    be_q;
  logic          cap_hit;

  assign accept = req_i && !active;

  art_cfg_latch #(.CW(CW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .rd_setup_i (rd_setup_i),
    .rd_pulse_i (rd_pulse_i),
    .rd_cycle_i (rd_cycle_i),
    .cs_setup_i (cs_setup_i),
    .cs_pulse_i (cs_pulse_i),
    .cap_sel_i  (cap_rd_i ? CAP_RD : CAP_CS),
    .len_o      (len),
    .rd_setup_o (st_setup[1]),
    .rd_stop_o  (st_stop[1]),
    .cs_setup_o (st_setup[0]),
    .cs_stop_o  (st_stop[0]),
    .cap_sel_o  (cap_sel_q)
  );

  art_seq #(.CW(CW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .len_i    (len),
    .active_o (active),
    .cnt_o    (cnt),
    .done_o   (done_o)
  );

  for (genvar g = 0; g < NS; g++) begin : g_strobe
    art_strobe #(.CW(CW)) u_strobe (
      .active_i  (active),
      .cnt_i     (cnt),
      .setup_i   (st_setup[g]),
      .stop_i    (st_stop[g]),
      .strobe_no (st_n[g]),
      .rise_o    (st_rise[g])
    );
  end

  assign mem_cs_no = st_n[0];
  assign mem_rd_no = st_n[1];
  assign cap_hit   = (cap_sel_q == CAP_RD) ? st_rise[1] : st_rise[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      be_q       <= '0;
      rdata_o    <= '0;
    end else begin
      if (accept) begin
        mem_addr_o <= addr_i;
        be_q       <= be_i;
      end
      if (cap_hit) rdata_o <= mem_data_i;
    end
  end

  assign mem_be_no = active ? ~be_q : 2'b11;
endmodule

// File: rtl/art_checker.sv
module art_checker #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic [DW-1:0] rdata_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    mem_be_no,
  input logic          mem_cs_no,
  input logic          mem_rd_no,
  input logic [DW-1:0] mem_data_i,
  input logic          cap_rd_i
);
  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_idle_strobes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mem_cs_no && mem_rd_no));
  p_be_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mem_be_no == 2'b11));
  p_addr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd_no |=> (mem_rd_no || $stable(mem_addr_o)));
  p_rdata_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> $stable(rdata_o));
  p_capture_rd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_rd_no) && $past(cap_rd_i)) |-> (rdata_o == $past(mem_data_i)));
  p_capture_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_cs_no) && !$past(cap_rd_i)) |-> (rdata_o == $past(mem_data_i)));
endmodule

bind async_rd_timer art_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .rdata_o    (rdata_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_no  (mem_be_no),
  .mem_cs_no  (mem_cs_no),
  .mem_rd_no  (mem_rd_no),
  .mem_data_i (mem_data_i),
  .cap_rd_i   (cap_sel_q == art_pkg::CAP_RD)
);

// File: tb/tb_async_rd_timer.sv
`timescale 1ns/1ps
module tb_async_rd_timer;
  localparam int AW = 20, DW = 16, CW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req = 0, cap_rd = 1;
  logic [AW-1:0] addr = '0;
  logic [1:0] be = 2'b11;
  logic [CW-1:0] rd_setup = 0, rd_pulse = 1, rd_cycle = 1, cs_setup = 0, cs_pulse = 1;
  logic [DW-1:0] mem_data = 16'h1000;
  logic done;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_be_n;
  logic mem_cs_n, mem_rd_n;

  async_rd_timer #(.AW(AW), .DW(DW), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .be_i(be),
    .rd_setup_i(rd_setup), .rd_pulse_i(rd_pulse), .rd_cycle_i(rd_cycle),
    .cs_setup_i(cs_setup), .cs_pulse_i(cs_pulse), .cap_rd_i(cap_rd),
    .done_o(done), .rdata_o(rdata), .mem_addr_o(mem_addr), .mem_be_no(mem_be_n),
    .mem_cs_no(mem_cs_n), .mem_rd_no(mem_rd_n), .mem_data_i(mem_data)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_en = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // data bus changes every clock so a capture one edge off is visible
  always @(negedge clk) mem_data <= mem_data + 16'h0101;

  // behavioural reference, state valid after each rising edge
  bit m_act = 0, m_done = 0, m_mode = 0;
  int m_k = 0, m_len = 1, m_rs = 0, m_re = 1, m_cs = 0, m_ce = 1;
  int m_rdata = 0, m_addr = 0, m_be = 0;

  function automatic int win_end(int s, int p, int len);
    int e;
    e = s + ((p == 0) ? 1 : p);
    return (e < len) ? e : len;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_done = 0; m_rdata = 0; m_addr = 0; m_be = 0; m_k = 0;
    end else begin
      bit nd;
      nd = 0;
      if (m_act) begin
        if ((m_mode && m_k == m_re - 1) || (!m_mode && m_k == m_ce - 1)) m_rdata = mem_data;
        if (m_k == m_len - 1) begin m_act = 0; nd = 1; end
        else m_k++;
      end else if (req) begin
        m_len = (rd_cycle == 0) ? 1 : int'(rd_cycle);
        m_rs = rd_setup; m_re = win_end(rd_setup, rd_pulse, m_len);
        m_cs = cs_setup; m_ce = win_end(cs_setup, cs_pulse, m_len);
        m_mode = cap_rd; m_addr = addr; m_be = be;
        m_act = 1; m_k = 0;
      end
      m_done = nd;
    end
  end

  always @(negedge clk) if (cmp_en && rst_n) begin
    bit e_rd, e_cs;
    e_rd = !(m_act && m_k >= m_rs && m_k < m_re);
    e_cs = !(m_act && m_k >= m_cs && m_k < m_ce);
    chk(mem_rd_n == e_rd, "R2 read strobe", mem_rd_n, e_rd);
    chk(mem_cs_n == e_cs, "R3 chip select", mem_cs_n, e_cs);
    chk(done == m_done, "R7 done", done, m_done);
    chk(rdata == DW'(m_rdata), m_mode ? "R5 capture on read" : "R6 capture on cs", rdata, m_rdata);
    chk(mem_addr == AW'(m_addr), "R8 address", mem_addr, m_addr);
    chk(mem_be_n == (m_act ? ~2'(m_be) : 2'b11), "R8 byte selects", mem_be_n,
        m_act ? ~2'(m_be) : 2'b11);
  end

  task automatic do_read(input int rs, rp, rc, cs, cp, input bit mode, input bit scramble,
                         output int n_cyc, output int n_rd, output int n_cs, output int first_rd);
    @(negedge clk);
    rd_setup = CW'(rs); rd_pulse = CW'(rp); rd_cycle = CW'(rc);
    cs_setup = CW'(cs); cs_pulse = CW'(cp); cap_rd = mode;
    addr = addr + AW'(20'h1_2345); be = be + 2'd1;
    req = 1;
    @(posedge clk);
    n_cyc = 0; n_rd = 0; n_cs = 0; first_rd = -1;
    forever begin
      @(negedge clk);
      req = 0;
      if (scramble) begin
        rd_setup = 9; rd_pulse = 9; rd_cycle = 30; cs_setup = 7; cs_pulse = 2;
        cap_rd = !mode; addr = ~addr; be = ~be;
      end
      if (done) break;
      if (!mem_rd_n) begin n_rd++; if (first_rd < 0) first_rd = n_cyc; end
      if (!mem_cs_n) n_cs++;
      n_cyc++;
      if (n_cyc > 300) break;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int nc, nr, ns, fr;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_rd_n, "R1 strobes in reset", {mem_cs_n, mem_rd_n}, 2'b11);
    chk(mem_be_n == 2'b11, "R1 byte selects in reset", mem_be_n, 2'b11);
    chk(!done && rdata == 0, "R1 done/data in reset", {done, rdata}, 0);
    rst_n = 1;
    cmp_en = 1;
    @(negedge clk);

    do_read(2, 3, 8, 1, 5, 1, 0, nc, nr, ns, fr);
    chk(nc == 8, "R7 cycle length", nc, 8);
    chk(nr == 3 && fr == 2, "R2 read window", nr * 16 + fr, 3 * 16 + 2);
    do_read(2, 3, 8, 1, 5, 0, 0, nc, nr, ns, fr);
    chk(ns == 5, "R3 chip-select width", ns, 5);
    do_read(1, 6, 9, 0, 2, 1, 0, nc, nr, ns, fr);
    do_read(0, 2, 6, 3, 1, 0, 0, nc, nr, ns, fr);
    do_read(4, 10, 7, 5, 9, 1, 0, nc, nr, ns, fr);
    chk(nr == 3 && ns == 2, "R3 windows clipped at cycle end", nr * 16 + ns, 3 * 16 + 2);

    do_read(1, 0, 5, 2, 0, 1, 0, nc, nr, ns, fr);
    chk(nr == 1, "R4 zero read pulse", nr, 1);
    chk(ns == 1, "R4 zero cs pulse", ns, 1);

    do_read(0, 4, 4, 0, 4, 1, 0, nc, nr, ns, fr);
    chk(fr == 0 && nr == 4, "R9 read low whole cycle", fr * 16 + nr, 4);
    chk(ns == 4, "R9 cs low whole cycle", ns, 4);

    do_read(0, 0, 0, 0, 0, 0, 0, nc, nr, ns, fr);
    chk(nc == 1, "R7 zero cycle acts as one", nc, 1);

    do_read(1, 2, 6, 2, 3, 1, 1, nc, nr, ns, fr);
    chk(nc == 6 && nr == 2 && ns == 3, "R10 settings latched", nc * 256 + nr * 16 + ns,
        6 * 256 + 2 * 16 + 3);

    // R11: request held high across a cycle and into its done clock
    @(negedge clk);
    rd_setup = 1; rd_pulse = 2; rd_cycle = 5; cs_setup = 0; cs_pulse = 3; cap_rd = 1;
    req = 1;
    nc = 0;
    @(negedge clk);
    while (!done && nc < 100) begin nc++; @(negedge clk); end
    chk(nc == 5, "R11 request ignored while busy", nc, 5);
    @(negedge clk); req = 0;
    chk(!mem_cs_n && !done, "R11 back-to-back start", {mem_cs_n, done}, 0);
    nc = 1;
    @(negedge clk);
    while (!done && nc < 100) begin nc++; @(negedge clk); end
    chk(nc == 5, "R11 second cycle length", nc, 5);

    held = rdata;
    repeat (6) @(negedge clk);
    chk(rdata == held, "R12 data held while idle", rdata, held);

    cmp_en = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule